// File: doc/BRIEF.md
# ADC Conversion Sequencer with Regular and Injected Groups

This block sits between software-written configuration and a single analog-to-digital conversion core. It decides which channel the core converts next and when it starts. Two channel lists are kept. The regular list has up to sixteen slots, and each slot may name any channel. The injected list has up to four slots. The injected list always has priority. An injected start aborts a regular conversion that is in flight, and the regular list later picks up again at the slot that was cut off.

A regular run can cover only the first slot, or the whole list (scan). It can repeat without end (continuous), or advance a few slots per trigger (chunked). Starts come from a software pulse or from a selectable edge of an external trigger line. Results are written to one regular result register, or to the injected result register that belongs to the slot. Sticky status flags report conversion ends, group starts and lost results.

The core handshake is simple. The request is held high with a stable channel number until the core pulses done with a data word. If the request drops without a done, the conversion is aborted.

Top module: `adc_seq`

## Requirements
- R1: A regular start is a one-cycle `sw_start` pulse or an edge of `ext_trig` chosen by `ext_mode`, where bit 0 enables the rising edge and bit 1 enables the falling edge (0 none, 1 rising, 2 falling, 3 both). The injected group uses `jsw_start`, `jext_trig` and `jext_mode` with the same encoding. A start that arrives while its group is already active is ignored.
- R2: With `scan_en` low, a regular start converts only slot 0 and then sets `eoc`.
- R3: With `scan_en` high, a regular start converts slots 0 to `reg_len` in order. `reg_len` holds the slot count minus one. Slot i takes its channel from `reg_slots[5*i +: 5]`.
- R4: With `eoc_each` high, `eoc` is set after every regular result. With `eoc_each` low, it is set only after the last slot of the run.
- R5: With `cont_en` high and chunking off, a finished regular run restarts at slot 0 without a trigger. Clearing `cont_en` lets the current run finish and then stop.
- R6: With `disc_en` high, each regular start converts the next `disc_num`+1 slots, or fewer if the list ends first. After the last slot, the next start begins again at slot 0.
- R7: An injected start converts slots 0 to `inj_len` in order, taking channels from `inj_slots[5*j +: 5]`. The result of slot j goes to `jdr[12*j +: 12]`, and `jeoc` is set after slot `inj_len`. With `jdisc_en` high, each start converts exactly one slot, continuing from the previous position.
- R8: When the injected group becomes active during a regular conversion, the regular request is dropped on the next clock edge. After the injected group, the interrupted regular slot is converted again and the list continues from there.
- R9: With `jauto` high, the injected group starts by itself after the last slot of a regular run, and the injected start inputs are ignored.
- R10: Flags are set by the block and held until cleared. `flag_clr` bit 0 clears `eoc`, bit 1 `jeoc`, bit 2 `strt`, bit 3 `jstrt` and bit 4 `ovr`. A `dr_read` pulse clears `eoc` only. `strt` and `jstrt` are set when a regular or an injected run is accepted.
- R11: If a regular result arrives while the previous one has not been read by `dr_read`, `ovr` is set and the new result is still written to `dr`. While `ovr` is set, no new regular conversion is issued. After `ovr` is cleared, the list resumes at the next slot.
- R12: `conv_chan` stays stable while `conv_req` is high. `conv_req` drops on the edge that samples `conv_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_en | input | 1 | Convert the whole regular list |
| cont_en | input | 1 | Restart regular runs automatically |
| eoc_each | input | 1 | Set EOC after every regular result |
| disc_en | input | 1 | Chunked regular mode |
| disc_num | input | 3 | Slots per chunk minus one |
| jdisc_en | input | 1 | One injected slot per start |
| jauto | input | 1 | Chain injected group after regular run |
| reg_len | input | 4 | Regular slot count minus one |
| reg_slots | input | 80 | Regular channel numbers, 5 bits per slot |
| inj_len | input | 2 | Injected slot count minus one |
| inj_slots | input | 20 | Injected channel numbers, 5 bits per slot |
| ext_mode | input | 2 | Regular external edge select |
| jext_mode | input | 2 | Injected external edge select |
| sw_start | input | 1 | Regular software start pulse |
| jsw_start | input | 1 | Injected software start pulse |
| ext_trig | input | 1 | Regular external trigger line |
| jext_trig | input | 1 | Injected external trigger line |
| conv_req | output | 1 | Conversion request to the core |
| conv_chan | output | 5 | Channel to convert |
| conv_done | input | 1 | Core result strobe |
| conv_data | input | 12 | Core result word |
| dr_read | input | 1 | Regular result read pulse |
| flag_clr | input | 5 | Per-flag clear pulses |
| dr | output | 12 | Regular result |
| jdr | output | 48 | Four injected results, 12 bits each |
| eoc | output | 1 | Regular end-of-conversion flag |
| jeoc | output | 1 | Injected end-of-group flag |
| strt | output | 1 | Regular run started flag |
| jstrt | output | 1 | Injected run started flag |
| ovr | output | 1 | Regular overrun flag |

## Verification
A start pulse or trigger edge sampled at edge t shows up in `strt`/`jstrt` right after t, and the first `conv_req` rises after edge t+1. A `conv_done` sampled at edge d updates `dr`, `jdr`, `eoc`, `jeoc` and `ovr` right after d. The next request rises after d+1, and a pre-empted regular request falls one edge after the injected group becomes active. The bench therefore samples flags two negative edges after each stimulus. It records `eoc` on the edge after each result, before its own read pulse takes effect. It judges channel order only after the request line has been idle long enough that nothing is left in flight.

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter int CW = 5,
  parameter int DW = 12,
  parameter int RSLOTS = 16,
  parameter int ISLOTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scan_en,
  input  logic                 cont_en,
  input  logic                 eoc_each,
  input  logic                 disc_en,
  input  logic [2:0]           disc_num,
  input  logic                 jdisc_en,
  input  logic                 jauto,
  input  logic [$clog2(RSLOTS)-1:0] reg_len,
  input  logic [RSLOTS*CW-1:0] reg_slots,
  input  logic [$clog2(ISLOTS)-1:0] inj_len,
  input  logic [ISLOTS*CW-1:0] inj_slots,
  input  logic [1:0]           ext_mode,
  input  logic [1:0]           jext_mode,
  input  logic                 sw_start,
  input  logic                 jsw_start,
  input  logic                 ext_trig,
  input  logic                 jext_trig,
  output logic                 conv_req,
  output logic [CW-1:0]        conv_chan,
  input  logic                 conv_done,
  input  logic [DW-1:0]        conv_data,
  input  logic                 dr_read,
  input  logic [4:0]           flag_clr,
  output logic [DW-1:0]        dr,
  output logic [ISLOTS*DW-1:0] jdr,
  output logic                 eoc,
  output logic                 jeoc,
  output logic                 strt,
  output logic                 jstrt,
  output logic                 ovr
);
  localparam int RW = $clog2(RSLOTS);
  localparam int IW = $clog2(ISLOTS);

  logic          ext_q, jext_q, cur_inj, rg_act, ij_act, dr_full;
  logic [RW-1:0] rg_idx;
  logic [IW-1:0] ij_idx;
  logic [2:0]    chunk;

  wire reg_trig = sw_start | (ext_mode[0] & ext_trig & ~ext_q) | (ext_mode[1] & ~ext_trig & ext_q);
  wire inj_trig = ~jauto & (jsw_start | (jext_mode[0] & jext_trig & ~jext_q) | (jext_mode[1] & ~jext_trig & jext_q));
  wire rg_end   = rg_idx == (scan_en ? reg_len : '0);
  wire ij_end   = ij_idx == inj_len;
  wire done_r   = conv_req & conv_done & ~cur_inj;
  wire done_i   = conv_req & conv_done & cur_inj;
  wire preempt  = conv_req & ~cur_inj & ij_act & ~conv_done;
  wire issue    = ~conv_req & (ij_act | (rg_act & ~ovr));
  wire rg_go    = reg_trig & ~rg_act;
  wire auto_go  = done_r & rg_end & jauto;
  wire ij_go    = inj_trig & ~ij_act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_q <= 1'b0; jext_q <= 1'b0;
    end else begin
      ext_q <= ext_trig; jext_q <= jext_trig;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conv_req <= 1'b0; conv_chan <= '0; cur_inj <= 1'b0;
    end else if (conv_req && (conv_done || preempt)) begin
      conv_req <= 1'b0;
    end else if (issue) begin
      conv_req  <= 1'b1;
      cur_inj   <= ij_act;
      conv_chan <= ij_act ? inj_slots[ij_idx*CW +: CW] : reg_slots[rg_idx*CW +: CW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rg_act <= 1'b0; rg_idx <= '0; chunk <= '0;
    end else if (done_r) begin
      if (rg_end) begin
        rg_idx <= '0;
        chunk  <= '0;
        rg_act <= cont_en & ~disc_en;
      end else begin
        rg_idx <= rg_idx + 1'b1;
        if (disc_en) begin
          if (chunk == disc_num) begin
            rg_act <= 1'b0;
            chunk  <= '0;
          end else chunk <= chunk + 1'b1;
        end
      end
    end else if (rg_go) begin
      rg_act <= 1'b1;
      chunk  <= '0;
      if (!disc_en) rg_idx <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ij_act <= 1'b0; ij_idx <= '0; jdr <= '0;
    end else if (done_i) begin
      jdr[ij_idx*DW +: DW] <= conv_data;
      if (ij_end) begin
        ij_idx <= '0;
        ij_act <= 1'b0;
      end else begin
        ij_idx <= ij_idx + 1'b1;
        if (jdisc_en) ij_act <= 1'b0;
      end
    end else if (auto_go) begin
      ij_act <= 1'b1;
      ij_idx <= '0;
    end else if (ij_go) begin
      ij_act <= 1'b1;
      if (!jdisc_en) ij_idx <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dr <= '0; dr_full <= 1'b0;
      eoc <= 1'b0; jeoc <= 1'b0; strt <= 1'b0; jstrt <= 1'b0; ovr <= 1'b0;
    end else begin
      if (done_r) dr <= conv_data;
      dr_full <= done_r | (dr_full & ~dr_read);
      eoc   <= (done_r & (eoc_each | rg_end)) | (eoc & ~flag_clr[0] & ~dr_read);
      jeoc  <= (done_i & ij_end) | (jeoc & ~flag_clr[1]);
      strt  <= rg_go | (strt & ~flag_clr[2]);
      jstrt <= auto_go | ij_go | (jstrt & ~flag_clr[3]);
      ovr   <= (done_r & dr_full & ~dr_read) | (ovr & ~flag_clr[4]);
    end
  end

  // R12
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && !conv_done && !ij_act) |=> (conv_req && $stable(conv_chan)));
  // R12
  done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && conv_done) |=> !conv_req);
  // R8
  preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && !cur_inj && ij_act && !conv_done) |=> !conv_req);
  // R11
  ovr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_req && ovr && !ij_act) |=> !conv_req);
  // R10
  eoc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && !flag_clr[0] && !dr_read) |=> eoc);
  // R10
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !flag_clr[4]) |=> ovr);
  // R7
  jeoc_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jeoc) |-> $past(conv_done && cur_inj));
endmodule

// File: tb/tb_adc_seq.sv
module tb_adc_seq;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scan_en = 0, cont_en = 0, eoc_each = 0, disc_en = 0, jdisc_en = 0, jauto = 0;
  logic [2:0] disc_num = 0;
  logic [3:0] reg_len = 0;
  logic [1:0] inj_len = 0, ext_mode = 0, jext_mode = 0;
  logic [79:0] reg_slots;
  logic [19:0] inj_slots;
  logic sw_start = 0, jsw_start = 0, ext_trig = 0, jext_trig = 0;
  logic conv_req, conv_done = 0;
  logic [4:0] conv_chan, flag_clr = 0;
  logic [11:0] conv_data = 0, dr;
  logic [47:0] jdr;
  logic eoc, jeoc, strt, jstrt, ovr;
  logic rd_q = 0, man_rd = 0, auto_rd = 1, pd = 0, prev_req = 0, prev_done = 0;
  wire dr_read = rd_q | man_rd;

  int checks = 0, errors = 0, nlog = 0, serial = 0, aborts = 0, cnt = 0, cyc = 0;
  logic [4:0] log_ch [0:255];
  logic       log_eoc [0:255];

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq dut (.clk(clk), .rst_n(rst_n), .scan_en(scan_en), .cont_en(cont_en), .eoc_each(eoc_each),
    .disc_en(disc_en), .disc_num(disc_num), .jdisc_en(jdisc_en), .jauto(jauto), .reg_len(reg_len),
    .reg_slots(reg_slots), .inj_len(inj_len), .inj_slots(inj_slots), .ext_mode(ext_mode),
    .jext_mode(jext_mode), .sw_start(sw_start), .jsw_start(jsw_start), .ext_trig(ext_trig),
    .jext_trig(jext_trig), .conv_req(conv_req), .conv_chan(conv_chan), .conv_done(conv_done),
    .conv_data(conv_data), .dr_read(dr_read), .flag_clr(flag_clr), .dr(dr), .jdr(jdr),
    .eoc(eoc), .jeoc(jeoc), .strt(strt), .jstrt(jstrt), .ovr(ovr));

  function automatic logic [4:0] rch(input int i); return 5'((i*5+2) % 19); endfunction
  function automatic logic [4:0] ich(input int j); return 5'((j*7+6) % 19); endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL R12 watchdog: actual cycles=%0d expected<=%0d", cyc, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  always @(posedge clk) begin
    pd <= conv_req && conv_done;
    prev_req <= conv_req;
    prev_done <= conv_done;
    if (prev_req && !conv_req && !prev_done) aborts = aborts + 1;
    if (conv_req && conv_done) begin
      log_ch[nlog[7:0]] = conv_chan;
      nlog = nlog + 1;
      serial = serial + 1;
    end
    if (pd) begin
      log_eoc[8'(nlog-1)] = eoc;
      rd_q <= auto_rd;
    end else rd_q <= 1'b0;
    if (!conv_req || conv_done) begin
      cnt <= 0;
      conv_done <= 1'b0;
    end else if (cnt == LAT-1) begin
      conv_done <= 1'b1;
      conv_data <= {serial[6:0], conv_chan};
    end else cnt <= cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_flags(input logic [4:0] m = 5'h1f);
    flag_clr = m; tick(); flag_clr = 0;
  endtask

  task automatic pulse_sw(); sw_start = 1; tick(); sw_start = 0; endtask
  task automatic pulse_jsw(); jsw_start = 1; tick(); jsw_start = 0; endtask

  task automatic wait_idle();
    int q = 0;
    while (q < 12) begin
      tick();
      q = conv_req ? 0 : q + 1;
    end
  endtask

  task automatic run_scan(input int len, input bit each);
    bit ok_o = 1, ok_e = 1;
    scan_en = 1; reg_len = 4'(len); eoc_each = each;
    clr_flags(); nlog = 0; pulse_sw(); wait_idle();
    chk(nlog == len+1, "R3 scan count", nlog, len+1);
    for (int k = 0; k <= len; k++) begin
      if (log_ch[k] != rch(k)) ok_o = 0;
      if (log_eoc[k] != (each || k == len)) ok_e = 0;
    end
    chk(ok_o, "R3 scan order", int'(ok_o), 1);
    chk(ok_e, "R4 eoc granularity", int'(ok_e), 1);
  endtask

  initial begin
    int pos, k;
    bit ok;
    for (int i = 0; i < 16; i++) reg_slots[i*5 +: 5] = rch(i);
    for (int j = 0; j < 4; j++) inj_slots[j*5 +: 5] = ich(j);
    tick(3); rst_n = 1; tick();
    chk(!conv_req && !eoc && !jeoc && !strt && !jstrt && !ovr, "R10 reset flags",
        {conv_req, eoc, jeoc, strt, jstrt, ovr}, 0);

    // R2 single conversion
    scan_en = 0; reg_len = 9; nlog = 0; pulse_sw(); tick();
    chk(strt, "R10 strt on start", strt, 1);
    wait_idle();
    chk(nlog == 1 && log_ch[0] == rch(0), "R2 single slot", nlog, 1);
    chk(log_eoc[0] == 1, "R2 eoc after single", log_eoc[0], 1);

    // R3 R4 sweep
    for (int len = 0; len < 16; len++)
      for (int e = 0; e < 2; e++) run_scan(len, e[0]);

    // R1 edge selection
    scan_en = 0;
    for (int m = 0; m < 4; m++) begin
      ext_mode = 2'(m); jext_mode = 2'(m);
      clr_flags(); nlog = 0; ext_trig = 1; tick(2);
      chk(strt == m[0], "R1 rising edge regular", strt, m[0]);
      wait_idle(); clr_flags(); ext_trig = 0; tick(2);
      chk(strt == m[1], "R1 falling edge regular", strt, m[1]);
      wait_idle();
      chk(nlog == m[0] + m[1], "R1 regular trigger count", nlog, m[0] + m[1]);
      inj_len = 0; clr_flags(); nlog = 0; jext_trig = 1; tick(2);
      chk(jstrt == m[0], "R1 rising edge injected", jstrt, m[0]);
      wait_idle(); clr_flags(); jext_trig = 0; tick(2);
      chk(jstrt == m[1], "R1 falling edge injected", jstrt, m[1]);
      wait_idle();
    end
    ext_mode = 0; jext_mode = 0;

    // R5 continuous
    scan_en = 1; reg_len = 2; cont_en = 1; eoc_each = 0; nlog = 0;
    pulse_sw(); tick(60); cont_en = 0; wait_idle();
    chk(nlog >= 6 && nlog % 3 == 0, "R5 continuous whole runs", nlog, 6);
    ok = 1;
    for (int q = 0; q < nlog; q++) if (log_ch[q] != rch(q % 3)) ok = 0;
    chk(ok, "R5 continuous order", int'(ok), 1);

    // R6 chunked
    reg_len = 9; disc_en = 1; pos = 0;
    for (int n = 1; n <= 8; n++) begin
      disc_num = 3'(n-1);
      for (int t = 0; t < 3; t++) begin
        nlog = 0; pulse_sw(); wait_idle();
        k = (10 - pos < n) ? 10 - pos : n;
        ok = (nlog == k);
        for (int q = 0; q < k; q++) if (log_ch[q] != rch(pos+q)) ok = 0;
        chk(ok, "R6 chunk slots", nlog, k);
        pos = (pos + k == 10) ? 0 : pos + k;
      end
    end
    while (pos != 0) begin
      pulse_sw(); wait_idle();
      pos = (pos + 8 >= 10) ? 0 : pos + 8;
    end
    disc_en = 0;

    // R7 injected group
    for (int il = 0; il < 4; il++) begin
      inj_len = 2'(il); clr_flags(); nlog = 0; pulse_jsw(); wait_idle();
      ok = (nlog == il+1);
      for (int j = 0; j <= il; j++)
        if (log_ch[j] != ich(j) || jdr[j*12 +: 5] != ich(j)) ok = 0;
      chk(ok, "R7 injected slots and results", nlog, il+1);
      chk(jeoc && jstrt, "R7 jeoc jstrt", {jeoc, jstrt}, 3);
    end
    inj_len = 2; jdisc_en = 1; clr_flags();
    for (int t = 0; t < 3; t++) begin
      nlog = 0; pulse_jsw(); wait_idle();
      chk(nlog == 1 && log_ch[0] == ich(t), "R7 one injected slot per start", nlog, 1);
      chk(jeoc == (t == 2), "R7 jeoc at group end", jeoc, t == 2);
    end
    jdisc_en = 0;

    // R8 pre-emption
    scan_en = 1; reg_len = 5; inj_len = 1; nlog = 0; aborts = 0;
    pulse_sw();
    while (!(nlog == 2 && conv_req)) tick();
    pulse_jsw(); wait_idle();
    ok = (nlog == 8) && log_ch[0] == rch(0) && log_ch[1] == rch(1) && log_ch[2] == ich(0)
         && log_ch[3] == ich(1);
    for (int q = 2; q < 6; q++) if (log_ch[q+2] != rch(q)) ok = 0;
    chk(ok, "R8 resume at interrupted slot", nlog, 8);
    chk(aborts == 1, "R8 one aborted request", aborts, 1);

    // R9 automatic injection
    jauto = 1; reg_len = 2; clr_flags(); nlog = 0; pulse_sw(); wait_idle();
    ok = (nlog == 5) && log_ch[3] == ich(0) && log_ch[4] == ich(1);
    for (int q = 0; q < 3; q++) if (log_ch[q] != rch(q)) ok = 0;
    chk(ok, "R9 injected after regular run", nlog, 5);
    chk(jeoc && jstrt, "R9 flags", {jeoc, jstrt}, 3);
    clr_flags(); nlog = 0; pulse_jsw(); wait_idle();
    chk(nlog == 0 && !jstrt, "R9 injected start ignored", nlog, 0);
    jauto = 0;

    // R11 overrun and R10 hold/clear
    auto_rd = 0; reg_len = 3; eoc_each = 1; clr_flags(); nlog = 0; pulse_sw(); wait_idle();
    chk(ovr == 1, "R11 ovr set", ovr, 1);
    chk(nlog == 2, "R11 conversions stop", nlog, 2);
    chk(dr[4:0] == rch(1), "R11 new result written", dr[4:0], rch(1));
    tick(20);
    chk(eoc && ovr && strt, "R10 flags held", {eoc, ovr, strt}, 7);
    clr_flags(5'b00100); tick();
    chk(!strt && eoc && ovr, "R10 strt clear only", {eoc, ovr, strt}, 6);
    man_rd = 1; tick(); man_rd = 0; tick();
    chk(!eoc && ovr, "R10 read clears eoc only", {eoc, ovr}, 1);
    auto_rd = 1; clr_flags(5'b10000); wait_idle();
    chk(nlog == 4 && log_ch[2] == rch(2) && log_ch[3] == rch(3), "R11 resume after clear", nlog, 4);
    chk(!ovr, "R10 ovr cleared", ovr, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule